// File: doc/BRIEF.md
# Receive Destination Address Filter

The filter takes the 48-bit destination address of each received frame, presented with a one-cycle strobe. One cycle later it reports whether the frame is kept, together with a code that gives the reason. Software sets it up through a small word-wide register port. The port holds a mode word, a multicast hash bit table and a table of exact-match address entries. Entry 0 holds the station's own address, and entries 1 and up hold additional addresses.

The hash bin of an address comes from a CRC-32 over the six address bytes. The CRC is the reflected form with polynomial 0xEDB88320, starting from all ones. The bytes are taken in transmit order, each byte least significant bit first. The remainder is complemented and bit-reversed, and the upper `HASH_BITS` bits of the result form the bin number. `HASH_BITS` is 6, 7 or 8, so the table has 64, 128 or 256 bins.

Address byte k is carried on `dst_addr_i[8k+7:8k]`. Byte 0 is the first byte transmitted, and its bit 0 (`dst_addr_i[0]`) is the group bit.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `dec_vld_o`, `accept_o` and `reason_o` are 0, and every register reads back as 0.
- R2: When `addr_vld_i` is high at a rising edge, the result appears on the outputs directly after that edge with `dec_vld_o`=1. Without a strobe, `dec_vld_o`, `accept_o` and `reason_o` are 0.
- R3: When mode bit 0 (promiscuous) is set, every address is accepted with reason 1, including broadcast and control addresses.
- R4: Outside promiscuous mode, the all-ones address is accepted with reason 2. When mode bit 4 (broadcast disable) is set, it is rejected with reason 0.
- R5: An address equal to a valid, non-zero exact-match entry is accepted with reason 3. This includes entry 0, the station address.
- R6: An entry never matches if its valid bit is clear, or if its stored address is all zeros. This holds even when the incoming address is zero.
- R7: Hash bin b tests bit b[4:0] of hash word b[HASH_BITS-1:5]. Hash word w sits at register address 0x10+w.
- R8: When mode bit 2 (hash multicast) is set and bit 1 is clear, a group address whose hash bin is set is accepted with reason 4. Otherwise a group address is accepted only through R10, or else rejected with reason 0. When bits 1 and 2 are both clear, group addresses pass only by an exact match (reason 3).
- R9: When mode bit 1 (all multicast) is set, every non-broadcast group address is accepted with reason 5.
- R10: When mode bit 3 (hash-or-exact) is set, two more cases are accepted. An individual address with no exact match is accepted with reason 4 if its hash bin is set. A group address that misses the hash table in hash multicast mode is accepted with reason 3 if it matches an entry.
- R11: A register write in the same cycle as a strobe does not affect that strobe's decision. The decision uses the configuration held before the write.
- R12: The registers read back as written on `reg_rdata_o`, combinationally from `reg_addr_i`. The register map is:
  - 0x00: mode, bits [4:0].
  - 0x40+2i: low 32 bits of entry i's address.
  - 0x41+2i: bits [15:0] hold address bits 47:32, and bit 31 is the valid bit.
  - Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 8 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| addr_vld_i | input | 1 | Destination address strobe |
| dst_addr_i | input | 48 | Destination address, byte 0 in bits 7:0 |
| dec_vld_o | output | 1 | Decision valid |
| accept_o | output | 1 | Frame accepted |
| reason_o | output | 3 | 0 reject, 1 promiscuous, 2 broadcast, 3 exact, 4 hash, 5 all multicast |

## Verification
Configuration writes and address lookups can land on the same clock edge. The bench provokes this by writing the promiscuous bit in the very cycle it strobes an address that the old configuration rejects. It expects a rejection for that strobe and an acceptance for the next one. The decision logic is then swept over all 32 mode words against a fixed set of addresses. Each hash bin is also set alone and probed with many group addresses. The expected results come from a CRC and a priority model computed inside the bench.

// File: rtl/raf_pkg.sv
package raf_pkg;
  typedef enum logic [2:0] {
    RSN_NONE    = 3'd0,
    RSN_PROMISC = 3'd1,
    RSN_BCAST   = 3'd2,
    RSN_EXACT   = 3'd3,
    RSN_HASH    = 3'd4,
    RSN_ALLMC   = 3'd5
  } reason_e;

  typedef struct packed {
    logic bcast_dis;
    logic hash_or_exact;
    logic hash_mc;
    logic all_mc;
    logic promisc;
  } mode_t;

  localparam logic [7:0] MODE_ADDR = 8'h00;
  localparam logic [7:0] HASH_BASE = 8'h10;
  localparam logic [7:0] ENT_BASE  = 8'h40;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
endpackage

// File: rtl/raf_hash.sv
module raf_hash #(
  parameter int HASH_BITS = 6
) (
  input  logic [47:0]          addr_i,
  output logic [HASH_BITS-1:0] bin_o
);
  import raf_pkg::*;

  logic [31:0] crc;

  // reflected CRC, bits in transmit order
  always_comb begin
    crc = '1;
    for (int i = 0; i < 48; i++) begin
      if (crc[0] ^ addr_i[i]) crc = (crc >> 1) ^ CRC_POLY;
      else                    crc = crc >> 1;
    end
  end

  // top bits of bitrev(~crc) == reversed low bits of ~crc
  always_comb begin
    for (int k = 0; k < HASH_BITS; k++) bin_o[k] = ~crc[HASH_BITS-1-k];
  end
endmodule

// File: rtl/raf_cam.sv
module raf_cam #(
  parameter int NUM_ENT = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_ENT-1:0][47:0] ent_addr_i,
  input  logic [NUM_ENT-1:0]       ent_vld_i,
  input  logic [47:0]              addr_i,
  output logic                     hit_o
);
  logic [NUM_ENT-1:0] hit_vec;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    assign hit_vec[g] = ent_vld_i[g] && (|ent_addr_i[g]) && (ent_addr_i[g] == addr_i);
  end

  assign hit_o = |hit_vec;

  p_zero_never_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 48'h0) |-> !hit_o);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int NUM_PERFECT = 4,
  parameter int HASH_BITS   = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        addr_vld_i,
  input  logic [47:0] dst_addr_i,
  output logic        dec_vld_o,
  output logic        accept_o,
  output logic [2:0]  reason_o
);
  import raf_pkg::*;

  localparam int HASH_WORDS = 2 ** (HASH_BITS - 5);
  localparam int WSEL_W     = (HASH_BITS > 5) ? HASH_BITS - 5 : 1;

  mode_t                          mode_q;
  logic [HASH_WORDS-1:0][31:0]    hash_q;
  logic [NUM_PERFECT-1:0][47:0]   ent_addr_q;
  logic [NUM_PERFECT-1:0]         ent_vld_q;

  // configuration writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= '0;
      hash_q     <= '0;
      ent_addr_q <= '0;
      ent_vld_q  <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == MODE_ADDR) mode_q <= mode_t'(reg_wdata_i[4:0]);
      for (int w = 0; w < HASH_WORDS; w++)
        if (reg_addr_i == HASH_BASE + 8'(w)) hash_q[w] <= reg_wdata_i;
      for (int i = 0; i < NUM_PERFECT; i++) begin
        if (reg_addr_i == ENT_BASE + 8'(2*i)) ent_addr_q[i][31:0] <= reg_wdata_i;
        if (reg_addr_i == ENT_BASE + 8'(2*i+1)) begin
          ent_addr_q[i][47:32] <= reg_wdata_i[15:0];
          ent_vld_q[i]         <= reg_wdata_i[31];
        end
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == MODE_ADDR) reg_rdata_o = {27'd0, mode_q};
    for (int w = 0; w < HASH_WORDS; w++)
      if (reg_addr_i == HASH_BASE + 8'(w)) reg_rdata_o = hash_q[w];
    for (int i = 0; i < NUM_PERFECT; i++) begin
      if (reg_addr_i == ENT_BASE + 8'(2*i)) reg_rdata_o = ent_addr_q[i][31:0];
      if (reg_addr_i == ENT_BASE + 8'(2*i+1))
        reg_rdata_o = {ent_vld_q[i], 15'd0, ent_addr_q[i][47:32]};
    end
  end

  logic [HASH_BITS-1:0] bin;
  logic                 hash_hit, exact_hit;
  logic [WSEL_W-1:0]    wsel;

  raf_hash #(.HASH_BITS(HASH_BITS)) u_hash (
    .addr_i (dst_addr_i),
    .bin_o  (bin)
  );

  raf_cam #(.NUM_ENT(NUM_PERFECT)) u_cam (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ent_addr_i (ent_addr_q),
    .ent_vld_i  (ent_vld_q),
    .addr_i     (dst_addr_i),
    .hit_o      (exact_hit)
  );

  assign wsel     = WSEL_W'(bin >> 5);
  assign hash_hit = hash_q[wsel][bin[4:0]];

  reason_e rsn_d;
  logic    is_bcast, is_group;

  assign is_bcast = &dst_addr_i;
  assign is_group = dst_addr_i[0];

  // fixed priority: promiscuous, broadcast, group rules, individual rules
  always_comb begin
    rsn_d = RSN_NONE;
    if (mode_q.promisc)                                    rsn_d = RSN_PROMISC;
    else if (is_bcast)                                     rsn_d = mode_q.bcast_dis ? RSN_NONE : RSN_BCAST;
    else if (is_group) begin
      if (mode_q.all_mc)                                   rsn_d = RSN_ALLMC;
      else if (mode_q.hash_mc) begin
        if (hash_hit)                                      rsn_d = RSN_HASH;
        else if (mode_q.hash_or_exact && exact_hit)        rsn_d = RSN_EXACT;
      end else if (exact_hit)                              rsn_d = RSN_EXACT;
    end else begin
      if (exact_hit)                                       rsn_d = RSN_EXACT;
      else if (mode_q.hash_or_exact && hash_hit)           rsn_d = RSN_HASH;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_vld_o <= 1'b0;
      accept_o  <= 1'b0;
      reason_o  <= 3'd0;
    end else begin
      dec_vld_o <= addr_vld_i;
      accept_o  <= addr_vld_i && (rsn_d != RSN_NONE);
      reason_o  <= addr_vld_i ? rsn_d : RSN_NONE;
    end
  end

  p_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_vld_i |=> (!dec_vld_o && !accept_o));
  p_promisc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_vld_i && mode_q.promisc) |=> (accept_o && reason_o == 3'd1));
  p_bcast_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_vld_i && !mode_q.promisc && (&dst_addr_i) && !mode_q.bcast_dis)
      |=> (accept_o && reason_o == 3'd2));
  p_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld_o |-> (accept_o == (reason_o != 3'd0)));
  p_allmc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_vld_i && mode_q.all_mc && !mode_q.promisc && dst_addr_i[0] && !(&dst_addr_i))
      |=> (reason_o == 3'd5));
endmodule

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;
  localparam int NP = 4;
  localparam int HB = 6;
  localparam int HW = 2 ** (HB - 5);

  logic        clk = 0, rst_ni = 0;
  logic        reg_we = 0, addr_vld = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [47:0] dst_addr = 0;
  logic        dec_vld, accept;
  logic [2:0]  reason;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [4:0]  sh_mode;
  logic [31:0] sh_hash [HW];
  logic [47:0] sh_ent  [NP];
  logic        sh_vld  [NP];

  always #2 clk = ~clk;

  rx_addr_filter #(.NUM_PERFECT(NP), .HASH_BITS(HB)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .addr_vld_i(addr_vld),
    .dst_addr_i(dst_addr), .dec_vld_o(dec_vld), .accept_o(accept), .reason_o(reason));

  function automatic int bin_of(input logic [47:0] a);
    logic [31:0] c, r;
    c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      c = c ^ {24'd0, a[8*b +: 8]};
      for (int s = 0; s < 8; s++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    c = ~c;
    for (int k = 0; k < 32; k++) r[k] = c[31-k];
    return int'(r >> (32 - HB));
  endfunction

  function automatic int model(input logic [47:0] a);
    bit ex = 0, hh;
    int bn;
    for (int i = 0; i < NP; i++) if (sh_vld[i] && a != 0 && sh_ent[i] == a) ex = 1;
    bn = bin_of(a);
    hh = sh_hash[bn / 32][bn % 32];
    if (sh_mode[0]) return 1;
    if (&a) return sh_mode[4] ? 0 : 2;
    if (a[0]) begin
      if (sh_mode[1]) return 5;
      if (sh_mode[2]) return hh ? 4 : ((sh_mode[3] && ex) ? 3 : 0);
      return ex ? 3 : 0;
    end
    if (ex) return 3;
    return (sh_mode[3] && hh) ? 4 : 0;
  endfunction

  function automatic string tag_of(input int r, input logic [47:0] a);
    case (r)
      1: return "R3"; 2: return "R4"; 3: return "R5"; 4: return "R8"; 5: return "R9";
      default: return (&a) ? "R4" : "R6";
    endcase
  endfunction

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ad, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = ad; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic set_mode(input logic [4:0] m);
    wr(8'h00, {27'd0, m}); sh_mode = m;
  endtask

  task automatic set_hash(input int w, input logic [31:0] d);
    wr(8'(8'h10 + w), d); sh_hash[w] = d;
  endtask

  task automatic set_ent(input int i, input logic [47:0] a, input logic v);
    wr(8'(8'h40 + 2*i), a[31:0]);
    wr(8'(8'h41 + 2*i), {v, 15'd0, a[47:32]});
    sh_ent[i] = a; sh_vld[i] = v;
  endtask

  task automatic probe(input logic [47:0] a, input string t);
    int e;
    e = model(a);
    @(negedge clk); addr_vld = 1; dst_addr = a;
    @(negedge clk); addr_vld = 0;
    chk({t, " dec_vld (R2)"}, {31'd0, dec_vld}, 32'd1);
    chk({t, " reason"}, {29'd0, reason}, 32'(e));
    chk({t, " accept"}, {31'd0, accept}, {31'd0, e != 0});
  endtask

  function automatic logic [47:0] mc_addr(input int k);
    return {8'(k*13+5), 8'(k), 8'h5E, 8'h00, 8'(k ^ 8'h40), 8'(8'h01 | (k << 1))};
  endfunction

  localparam logic [47:0] STA = 48'h0A0B0C0D0E02;
  localparam logic [47:0] UC1 = 48'h665544332210;
  localparam logic [47:0] MCE = 48'h00000000AB01;
  localparam logic [47:0] UNK = 48'h123456789A04;

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    sh_mode = 0;
    for (int w = 0; w < HW; w++) sh_hash[w] = 0;
    for (int i = 0; i < NP; i++) begin sh_ent[i] = 0; sh_vld[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1
    chk("R1 dec_vld", {31'd0, dec_vld}, 0);
    chk("R1 reason", {29'd0, reason}, 0);
    for (int a = 0; a < 256; a++) begin
      reg_addr = 8'(a); #0.1;
      chk("R1 readback zero", reg_rdata, 0);
    end

    // R12 readback
    set_ent(0, STA, 1);
    set_ent(1, UC1, 1);
    set_ent(2, 48'h0, 1);   // zero pattern, valid
    set_ent(3, MCE, 0);     // invalid
    set_hash(0, 32'hA5A5_0F0F);
    set_hash(1, 32'h1234_C3C3);
    set_mode(5'b10110);
    @(negedge clk);
    reg_addr = 8'h00; #0.1; chk("R12 mode", reg_rdata, 32'h16);
    reg_addr = 8'h11; #0.1; chk("R12 hash1", reg_rdata, 32'h1234_C3C3);
    reg_addr = 8'h42; #0.1; chk("R12 ent1 lo", reg_rdata, 32'h44332210);
    reg_addr = 8'h43; #0.1; chk("R12 ent1 hi", reg_rdata, 32'h80006655);
    reg_addr = 8'h47; #0.1; chk("R12 ent3 hi", reg_rdata, 32'h0000_0000);
    reg_addr = 8'h30; #0.1; chk("R12 unmapped", reg_rdata, 0);

    // R2: no strobe -> nothing
    @(negedge clk);
    chk("R2 idle dec_vld", {31'd0, dec_vld}, 0);
    chk("R2 idle accept", {31'd0, accept}, 0);

    // R6 explicit
    set_mode(5'b00000);
    probe(48'h0, "R6 zero entry");
    probe({MCE[47:1], 1'b0}, "R6 invalid entry unicast");
    set_ent(3, {MCE[47:1], 1'b0}, 0);
    probe({MCE[47:1], 1'b0}, "R6 invalid entry");
    set_ent(3, MCE, 1);

    // sweep all mode words over an address set (R3 R4 R5 R8 R9 R10)
    for (int m = 0; m < 32; m++) begin
      set_mode(5'(m));
      probe(48'hFFFF_FFFF_FFFF, tag_of(model(48'hFFFF_FFFF_FFFF), 48'hFFFF_FFFF_FFFF));
      probe(STA, "R5 station");
      probe(UC1, "R5 entry1");
      probe(MCE, "R10 group exact");
      probe(UNK, "R10 unicast hash");
      probe(48'h0, "R6 zero");
      probe(48'h0180C2000001, "R3 control");
      for (int k = 0; k < 12; k++) probe(mc_addr(k), tag_of(model(mc_addr(k)), mc_addr(k)));
    end

    // R7 R8: each bin alone
    set_mode(5'b00100);
    for (int b = 0; b < 2**HB; b++) begin
      for (int w = 0; w < HW; w++) set_hash(w, (w == b/32) ? (32'd1 << (b%32)) : 32'd0);
      for (int k = 0; k < 24; k++) probe(mc_addr(k + 3*b), "R7 bin select");
    end

    // R10 explicit
    for (int w = 0; w < HW; w++) set_hash(w, 32'hFFFF_FFFF);
    set_mode(5'b01000);
    probe(UNK, "R10 unicast by hash");
    set_mode(5'b00000);
    probe(UNK, "R10 unicast no hash");
    for (int w = 0; w < HW; w++) set_hash(w, 0);
    set_mode(5'b01100);
    probe(MCE, "R10 group exact on hash miss");

    // R11 write and strobe in the same cycle
    set_mode(5'b00000);
    @(negedge clk);
    reg_we = 1; reg_addr = 8'h00; reg_wdata = 32'h1;
    addr_vld = 1; dst_addr = UNK;
    @(negedge clk);
    reg_we = 0; addr_vld = 0;
    chk("R11 old config reason", {29'd0, reason}, 0);
    chk("R11 old config accept", {31'd0, accept}, 0);
    sh_mode = 5'b00001;
    probe(UNK, "R11 new config");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule